// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits on the host side of a three-wire serial EEPROM holding 64 words of 16 bits. A client hands it one request at a time: a three-bit operation code, a six-bit word address and a 16-bit data word. The block turns the request into a bit-serial frame. It drives the chip select, the shift clock and the serial data line from the system clock, and it counts every phase in system-clock cycles.

A read returns a 16-bit word after the block drops the leading dummy bit. The four programming commands (single erase, single write, whole-array erase and whole-array write) end with a status phase. In that phase chip select is raised again with no clock pulses, and the memory's data output is watched until it reports ready. If the memory is still busy when a configurable limit runs out, the block sets an error flag. Each request finishes with a one-cycle completion pulse.

Top module: `ser_eeprom_host`

## Requirements
- R1: Each frame shifts out MSB first on `di_o`, one bit per rising edge of `sk_o`: a start bit of 1, a two-bit wire opcode, then a six-bit address field. The wire opcodes are 10 for read (request code 0), 01 for write (code 1) and 11 for erase (code 2).
- R2: For write (code 1) and write-all (code 6), the 16 data bits follow the nine header bits MSB first, which makes 25 clock pulses in total.
- R3: Enable (code 3), disable (code 4), erase-all (code 5) and write-all (code 6) use wire opcode 00. The top two bits of the address field are 11, 00, 10 and 01 respectively, and the remaining four bits are 0. The first three of these commands send exactly nine clock pulses.
- R4: A read sends 25 clock pulses, with `di_o` held at 0 after the address. `do_i` is sampled at the end of each high phase. The sample taken on pulse 9 is a dummy and is discarded, and pulses 10 to 25 give data bits 15 down to 0 on `rd_data_o`, which is valid when `done_o` pulses.
- R5: `sk_o` high and low phases each last exactly `HALF_CLKS` clocks. `sk_o` is high only while `cs_o` is high. `di_o` never changes while `sk_o` is high.
- R6: After every frame and every status phase, `cs_o` stays low for at least `CSLOW_CLKS` clocks. This covers the gap before the status phase and before the next frame, and `done_o` comes only after that gap.
- R7: After codes 1, 2, 5 and 6, `cs_o` is raised with `sk_o` held low. A `do_i` of 0 means busy, and the command completes only once `do_i` reads 1.
- R8: If `do_i` has not read 1 within `POLL_LIMIT` clocks of the status phase, `err_o` goes high and the command still completes with `done_o`. `err_o` is cleared when the next request is accepted.
- R9: A request is taken only while `busy_o` is low. `busy_o` stays high from the cycle after acceptance until completion, and `done_o` is a single-cycle pulse. Requests offered while busy are ignored.
- R10: Request code 7 is ignored: no frame starts and neither `busy_o` nor `done_o` rises.
- R11: After reset, `cs_o`, `sk_o`, `di_o`, `busy_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Request code, 0 to 7 |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Data for the write and write-all commands |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Status phase ran out of time |
| rd_data_o | output | DW | Word returned by the last read |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Shift clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data and ready/busy status from the memory |

## Verification
The assertions assume that `do_i` changes only right after a rising edge of `sk_o`, or while the block sits in its status phase, so that a sample taken at the end of a high phase is clean. They also assume that requests arrive as single-cycle strobes. The bench's memory model changes its output only on shift-clock rising edges and from its busy timer. Every request is driven on the falling system-clock edge, so both assumptions hold throughout the stimulus.

// File: rtl/eeh_pkg.sv
package eeh_pkg;

  typedef enum logic [2:0] {
    REQ_READ  = 3'd0,
    REQ_WRITE = 3'd1,
    REQ_ERASE = 3'd2,
    REQ_WEN   = 3'd3,
    REQ_WDIS  = 3'd4,
    REQ_ERALL = 3'd5,
    REQ_WRALL = 3'd6,
    REQ_NONE  = 3'd7
  } req_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_POLL  = 2'd3
  } seq_state_e;

  localparam logic [1:0] WIRE_READ  = 2'b10;
  localparam logic [1:0] WIRE_WRITE = 2'b01;
  localparam logic [1:0] WIRE_ERASE = 2'b11;
  localparam logic [1:0] WIRE_EXT   = 2'b00;

  localparam logic [1:0] EXT_WEN   = 2'b11;
  localparam logic [1:0] EXT_WDIS  = 2'b00;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_WRALL = 2'b01;

endpackage

// File: rtl/eeh_frame_build.sv
module eeh_frame_build
  import eeh_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int FW = 3 + AW + DW,
  localparam int CW = $clog2(FW + 1)
) (
  input  req_op_e         op,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [FW-1:0]   frame,
  output logic [CW-1:0]   nbits,
  output logic            is_read,
  output logic            needs_poll,
  output logic            legal
);

  localparam int SHORT = 3 + AW;

  logic [1:0]    wire_op;
  logic [AW-1:0] field;
  logic          with_data;

  always_comb begin
    wire_op    = WIRE_EXT;
    field      = addr;
    with_data  = 1'b0;
    is_read    = 1'b0;
    needs_poll = 1'b0;
    legal      = 1'b1;
    unique case (op)
      REQ_READ: begin
        wire_op = WIRE_READ;
        is_read = 1'b1;
      end
      REQ_WRITE: begin
        wire_op    = WIRE_WRITE;
        with_data  = 1'b1;
        needs_poll = 1'b1;
      end
      REQ_ERASE: begin
        wire_op    = WIRE_ERASE;
        needs_poll = 1'b1;
      end
      REQ_WEN:  field = {EXT_WEN, {(AW-2){1'b0}}};
      REQ_WDIS: field = {EXT_WDIS, {(AW-2){1'b0}}};
      REQ_ERALL: begin
        field      = {EXT_ERALL, {(AW-2){1'b0}}};
        needs_poll = 1'b1;
      end
      REQ_WRALL: begin
        field      = {EXT_WRALL, {(AW-2){1'b0}}};
        with_data  = 1'b1;
        needs_poll = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

  // Header bits sit at the top so the shifter always sends from the MSB end.
  // A read also clocks a full data phase, with DI held low.
  always_comb begin
    frame = {1'b1, wire_op, field, (with_data ? wdata : {DW{1'b0}})};
    nbits = (with_data || is_read) ? CW'(FW) : CW'(SHORT);
  end

endmodule

// File: rtl/eeh_tick.sv
module eeh_tick #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = en && (cnt_q == lim);
    cnt_d = cnt_q;
    if (clr || hit) cnt_d = '0;
    else if (en)    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/eeh_rx.sv
module eeh_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [DW-1:0] data
);

  logic [DW-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[DW-2:0], din};
  end

  assign data = sh_q;

endmodule

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host
  import eeh_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int HALF_CLKS  = 32,
  parameter int CSLOW_CLKS = 32,
  parameter int POLL_LIMIT = 700000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [2:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rd_data_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  input  logic          do_i
);

  localparam int FW    = 3 + AW + DW;
  localparam int CW    = $clog2(FW + 1);
  localparam int SHORT = 3 + AW;
  localparam int TMAX  = (HALF_CLKS > CSLOW_CLKS) ? HALF_CLKS : CSLOW_CLKS;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  // Reset: asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // Frame for the request currently offered
  logic [FW-1:0] fb_frame;
  logic [CW-1:0] fb_nbits;
  logic          fb_read, fb_poll, fb_legal;

  eeh_frame_build #(.AW(AW), .DW(DW)) u_frame (
    .op         (req_op_e'(req_op_i)),
    .addr       (req_addr_i),
    .wdata      (req_wdata_i),
    .frame      (fb_frame),
    .nbits      (fb_nbits),
    .is_read    (fb_read),
    .needs_poll (fb_poll),
    .legal      (fb_legal)
  );

  // Sequencer state
  seq_state_e    st_q, st_d;
  logic          ph_q, ph_d;
  logic [CW-1:0] bidx_q, bidx_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] nbits_q, nbits_d;
  logic          rd_q, rd_d;
  logic          poll_q, poll_d;
  logic          polled_q, polled_d;
  logic          settled_q, settled_d;
  logic [PW-1:0] tmo_q, tmo_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  logic          tk_clr, tk_en, tk_hit;
  logic [TW-1:0] tk_lim;
  logic          rx_en;

  eeh_tick #(.W(TW)) u_tick (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (tk_clr),
    .en    (tk_en),
    .lim   (tk_lim),
    .hit   (tk_hit)
  );

  eeh_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_s),
    .shift_en (rx_en),
    .din      (do_i),
    .data     (rd_data_o)
  );

  // Phase timer: which limit applies, and whether it runs
  always_comb begin
    tk_en  = 1'b0;
    tk_lim = TW'(HALF_CLKS - 1);
    unique case (st_q)
      ST_SHIFT: tk_en = 1'b1;
      ST_GAP: begin
        tk_en  = 1'b1;
        tk_lim = TW'(CSLOW_CLKS - 1);
      end
      ST_POLL: tk_en = !settled_q;
      default: tk_en = 1'b0;
    endcase
  end

  // Next state
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    bidx_d    = bidx_q;
    sh_d      = sh_q;
    nbits_d   = nbits_q;
    rd_d      = rd_q;
    poll_d    = poll_q;
    polled_d  = polled_q;
    settled_d = settled_q;
    tmo_d     = tmo_q;
    err_d     = err_q;
    done_d    = 1'b0;
    tk_clr    = 1'b0;
    rx_en     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i && fb_legal) begin
          st_d     = ST_SHIFT;
          ph_d     = 1'b0;
          bidx_d   = '0;
          sh_d     = fb_frame;
          nbits_d  = fb_nbits;
          rd_d     = fb_read;
          poll_d   = fb_poll;
          polled_d = 1'b0;
          err_d    = 1'b0;
          tk_clr   = 1'b1;
        end
      end

      ST_SHIFT: begin
        if (tk_hit) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            // End of the high phase: take DO, then move DI on while SK is low.
            rx_en = rd_q && (bidx_q >= CW'(SHORT));
            ph_d  = 1'b0;
            sh_d  = {sh_q[FW-2:0], 1'b0};
            if (bidx_q == nbits_q - CW'(1)) st_d = ST_GAP;
            else                            bidx_d = bidx_q + CW'(1);
          end
        end
      end

      ST_GAP: begin
        if (tk_hit) begin
          if (poll_q && !polled_q) begin
            st_d      = ST_POLL;
            settled_d = 1'b0;
            tmo_d     = '0;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end

      ST_POLL: begin
        tmo_d = tmo_q + PW'(1);
        if (tk_hit) settled_d = 1'b1;
        if (settled_q && do_i) begin
          polled_d = 1'b1;
          st_d     = ST_GAP;
          tk_clr   = 1'b1;
        end else if (tmo_q == PW'(POLL_LIMIT - 1)) begin
          err_d    = 1'b1;
          polled_d = 1'b1;
          st_d     = ST_GAP;
          tk_clr   = 1'b1;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q      <= ST_IDLE;
      ph_q      <= 1'b0;
      bidx_q    <= '0;
      sh_q      <= '0;
      nbits_q   <= '0;
      rd_q      <= 1'b0;
      poll_q    <= 1'b0;
      polled_q  <= 1'b0;
      settled_q <= 1'b0;
      tmo_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      bidx_q    <= bidx_d;
      sh_q      <= sh_d;
      nbits_q   <= nbits_d;
      rd_q      <= rd_d;
      poll_q    <= poll_d;
      polled_q  <= polled_d;
      settled_q <= settled_d;
      tmo_q     <= tmo_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  // Outputs, decoded from registers only
  assign cs_o   = (st_q == ST_SHIFT) || (st_q == ST_POLL);
  assign sk_o   = (st_q == ST_SHIFT) && ph_q;
  assign di_o   = (st_q == ST_SHIFT) && sh_q[FW-1];
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/eeh_checker.sv
module eeh_checker #(
  parameter int HALF  = 32,
  parameter int CSLOW = 32,
  localparam int HW   = $clog2(HALF + 2),
  localparam int LW   = $clog2(CSLOW + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  logic [HW-1:0] hicnt;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hicnt <= '0;
    else if (!sk_o)                     hicnt <= '0;
    else if (hicnt != HW'(HALF + 1))    hicnt <= hicnt + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lowcnt <= LW'(CSLOW);
    else if (cs_o)                       lowcnt <= '0;
    else if (lowcnt < LW'(CSLOW))        lowcnt <= lowcnt + LW'(1);
  end

  p_sk_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> cs_o);

  p_di_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> $stable(di_o));

  p_sk_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk_o) |-> (hicnt == HW'(HALF)));

  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (lowcnt >= LW'(CSLOW)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !cs_o));

  p_err_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> busy_o);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cs_o && !sk_o && !di_o));

endmodule

bind ser_eeprom_host eeh_checker #(.HALF(HALF_CLKS), .CSLOW(CSLOW_CLKS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_o   (cs_o),
  .sk_o   (sk_o),
  .di_o   (di_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/tb_ser_eeprom_host.sv
`timescale 1ns/1ps
module tb_ser_eeprom_host;

  localparam int HALF  = 2;
  localparam int CSLOW = 3;
  localparam int PLIM  = 40;

  logic        clk, rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata;
  logic        busy_w, done_w, err_w, cs_w, sk_w, di_w, do_w;
  logic [15:0] rd_w;

  ser_eeprom_host #(.AW(6), .DW(16), .HALF_CLKS(HALF), .CSLOW_CLKS(CSLOW),
                    .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy_w),
    .done_o(done_w), .err_o(err_w), .rd_data_o(rd_w), .cs_o(cs_w),
    .sk_o(sk_w), .di_o(di_w), .do_i(do_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Memory model: captures frames, serves reads and ready/busy status
  longint      cyc;
  longint      busy_end;
  int          busy_clks;
  logic [15:0] mem [64];
  logic [24:0] fb, last_fb;
  int          nb, last_nb, nframes;
  logic        wen, poll_mode, rd_bit, rdm;
  logic [5:0]  raddr;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  always @(posedge sk_w or negedge cs_w or negedge rst_n) begin
    if (!rst_n) begin
      nb = 0; fb = '0; last_nb = 0; last_fb = '0; nframes = 0;
      wen = 1'b0; poll_mode = 1'b0; rd_bit = 1'b0; rdm = 1'b0;
      raddr = '0; busy_end = 0;
      for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    end else if (cs_w) begin
      fb = {fb[23:0], di_w};
      nb = nb + 1;
      if (nb == 9) begin
        rdm   = (fb[8:6] == 3'b110);
        raddr = fb[5:0];
      end
      if (rdm && nb == 9)                  rd_bit = 1'b0;
      else if (rdm && nb >= 10 && nb <= 25) rd_bit = mem[raddr][25-nb];
    end else begin
      if (nb == 0) begin
        poll_mode = 1'b0;
      end else begin
        logic [8:0]  cmd;
        logic [15:0] dat;
        logic        prog, wen_then;
        cmd = (nb == 25) ? fb[24:16] : fb[8:0];
        dat = fb[15:0];
        prog = 1'b0;
        wen_then = wen;
        case (cmd[7:6])
          2'b01: begin prog = 1'b1; if (wen) mem[cmd[5:0]] = dat; end
          2'b11: begin prog = 1'b1; if (wen) mem[cmd[5:0]] = 16'hFFFF; end
          2'b00: case (cmd[5:4])
            2'b11: wen = 1'b1;
            2'b00: wen = 1'b0;
            2'b10: begin prog = 1'b1;
              if (wen) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF; end
            default: begin prog = 1'b1;
              if (wen) for (int i = 0; i < 64; i++) mem[i] = dat; end
          endcase
          default: ;
        endcase
        if (prog) begin
          poll_mode = 1'b1;
          busy_end  = cyc + (wen_then ? longint'(busy_clks) : 0);
        end
        last_nb = nb; last_fb = fb; nframes = nframes + 1;
        nb = 0; fb = '0; rdm = 1'b0; rd_bit = 1'b0;
      end
    end
  end

  assign do_w = poll_mode ? (cyc >= busy_end) : rd_bit;

  // Pin timing monitor (R5 phase lengths, R6 chip-select gap)
  int   hi_run, lo_run, csl_run, sk_bad, gap_bad;
  logic sk_p, cs_p;

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; csl_run = 100; sk_bad = 0; gap_bad = 0;
      sk_p = 1'b0; cs_p = 1'b0;
    end else begin
      if (sk_w && !sk_p) begin
        if (lo_run != HALF) sk_bad++;
        hi_run = 1;
      end else if (!sk_w && sk_p) begin
        if (hi_run != HALF) sk_bad++;
        lo_run = 1;
      end else if (cs_w && !cs_p) begin
        lo_run = 1;
      end else begin
        hi_run++; lo_run++;
      end
      if (cs_w && !cs_p && csl_run < CSLOW) gap_bad++;
      if (cs_w) csl_run = 0; else csl_run++;
      sk_p = sk_w; cs_p = cs_w;
    end
  end

  function automatic logic [24:0] exp_frame(input int op, input int a,
                                            input logic [15:0] d, output int n);
    logic [5:0] aa;
    aa = 6'(a);
    case (op)
      0: begin n = 25; return {1'b1, 2'b10, aa, 16'h0}; end
      1: begin n = 25; return {1'b1, 2'b01, aa, d}; end
      2: begin n = 9;  return {16'h0, 1'b1, 2'b11, aa}; end
      3: begin n = 9;  return {16'h0, 1'b1, 2'b00, 6'b110000}; end
      4: begin n = 9;  return {16'h0, 1'b1, 2'b00, 6'b000000}; end
      5: begin n = 9;  return {16'h0, 1'b1, 2'b00, 6'b100000}; end
      default: begin n = 25; return {1'b1, 2'b00, 6'b010000, d}; end
    endcase
  endfunction

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 257) ^ 16'h5A3C;
  endfunction

  logic [15:0] got_rd;
  logic        got_err;

  task automatic run(input int op, input int a, input logic [15:0] d,
                     input bit inject, input string tag);
    int          nf0, en, w;
    logic [24:0] ef;
    nf0 = nframes;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = 6'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy_w === 1'b1, "R9 busy after accept", 32'(busy_w), 1);
    if (inject) begin
      req_valid = 1'b1; req_op = 3'd1; req_addr = 6'(a ^ 1); req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (done_w !== 1'b1 && w < 20000) begin @(negedge clk); w++; end
    chk(done_w === 1'b1, "R9 completion", 32'(done_w), 1);
    got_rd  = rd_w;
    got_err = err_w;
    ef = exp_frame(op, a, d, en);
    chk(last_nb == en, {tag, " pulse count"}, 32'(last_nb), 32'(en));
    chk(last_fb == ef, {tag, " frame bits"}, 32'(last_fb), 32'(ef));
    chk(nframes == nf0 + 1, "R9 one frame per request", 32'(nframes), 32'(nf0 + 1));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int nf0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    busy_clks = 15;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset values
    chk({cs_w, sk_w, di_w, busy_w, done_w, err_w} == 6'b0, "R11 reset outputs",
        32'({cs_w, sk_w, di_w, busy_w, done_w, err_w}), 0);

    // R10: code 7 ignored
    nf0 = nframes; seen = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_op = 3'd7;
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (busy_w || done_w || cs_w) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen && nframes == nf0, "R10 reserved code", 32'(seen), 0);

    // R3: enable
    run(3, 0, 16'h0, 1'b0, "R3 enable");

    // R2/R7: write sweep over all addresses
    for (int a = 0; a < 64; a++) begin
      run(1, a, pat(a), 1'b0, "R2 write");
      chk(got_err == 1'b0, "R7 write ready no error", 32'(got_err), 0);
      chk(cyc >= busy_end, "R7 done only after ready", 32'(cyc), 32'(busy_end));
    end

    // R1/R4: read sweep
    for (int a = 0; a < 64; a++) begin
      run(0, a, 16'h0, 1'b0, "R1 read");
      chk(got_rd == pat(a), "R4 read data", 32'(got_rd), 32'(pat(a)));
    end

    // R1: erase one word
    run(2, 7, 16'h0, 1'b0, "R1 erase");
    chk(cyc >= busy_end, "R7 erase polled", 32'(cyc), 32'(busy_end));
    run(0, 7, 16'h0, 1'b0, "R1 read");
    chk(got_rd == 16'hFFFF, "R4 erased word", 32'(got_rd), 32'hFFFF);
    run(0, 8, 16'h0, 1'b0, "R1 read");
    chk(got_rd == pat(8), "R4 neighbour kept", 32'(got_rd), 32'(pat(8)));

    // R2/R3: write all
    run(6, 0, 16'hC3A5, 1'b0, "R3 write-all");
    chk(cyc >= busy_end, "R7 write-all polled", 32'(cyc), 32'(busy_end));
    run(0, 0, 16'h0, 1'b0, "R1 read");
    chk(got_rd == 16'hC3A5, "R4 write-all low", 32'(got_rd), 32'hC3A5);
    run(0, 63, 16'h0, 1'b0, "R1 read");
    chk(got_rd == 16'hC3A5, "R4 write-all high", 32'(got_rd), 32'hC3A5);

    // R3: erase all
    run(5, 0, 16'h0, 1'b0, "R3 erase-all");
    run(0, 20, 16'h0, 1'b0, "R1 read");
    chk(got_rd == 16'hFFFF, "R4 erase-all data", 32'(got_rd), 32'hFFFF);

    // R8: status phase times out
    busy_clks = 1000;
    run(1, 9, 16'h1357, 1'b0, "R2 write");
    chk(got_err == 1'b1, "R8 timeout flag", 32'(got_err), 1);
    busy_clks = 15;
    repeat (1000) @(negedge clk);
    run(0, 9, 16'h0, 1'b0, "R1 read");
    chk(got_err == 1'b0, "R8 flag cleared", 32'(got_err), 0);
    chk(got_rd == 16'h1357, "R4 read after timeout", 32'(got_rd), 32'h1357);

    // R9: request while busy is ignored
    nf0 = nframes;
    run(0, 2, 16'h0, 1'b1, "R1 read");
    chk(got_rd == 16'hFFFF, "R9 read unaffected", 32'(got_rd), 32'hFFFF);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy_w || cs_w || done_w) seen = 1'b1;
    end
    chk(!seen && nframes == nf0 + 1, "R9 busy request dropped", 32'(nframes), 32'(nf0 + 1));

    // R3: disable
    run(4, 0, 16'h0, 1'b0, "R3 disable");

    // R5/R6 pin timing over the whole run
    chk(sk_bad == 0, "R5 clock phase length", 32'(sk_bad), 0);
    chk(gap_bad == 0, "R6 chip-select low gap", 32'(gap_bad), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule